// File: doc/BRIEF.md
# Block Protection and Lock Unit

This unit keeps the write-protection state of a memory divided into 71 blocks. Each block has a protect bit and a lock bit. Decoded commands arrive one per cycle with a block index. The unit sets or clears protect bits and sets lock bits. It answers program or erase requests with a grant or a refusal, and it returns a per-block status word. The memory array, its program and erase timing, and the decoding of raw bus cycles all sit outside the unit.

A power-up reset leaves every block protected and every lock bit clear. A lock bit matters only while the active-low write-protect input is held low. During that time, the protect bit of a locked block is frozen against both protect and unprotect commands. A soft reset command clears the error flag and leaves every protect and lock bit as it was. A program or erase request that is refused raises an error flag. That flag is reported once, by the next status read, and then it clears.

Top module: `blk_protect_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, every block reads as protected (status bit 0 = 1), every lock bit is 0, the error flag is 0, and `mod_ok`, `mod_deny` and `stat_vld` are 0.
- R2: A protect command (op 1) sets the protect bit of the indexed block only, and an unprotect command (op 2) clears it only, unless that block is frozen (see R6). A command issued in the following cycle already sees the change.
- R3: A modify request (op 4) makes exactly one of `mod_ok` or `mod_deny` high for one cycle, one clock after the request. The request is refused if the block is protected or if the index is 71 or higher.
- R4: A refused modify request sets the error flag. The next status read reports the flag in bit 2, and that same read clears it. A granted modify request leaves the flag unchanged.
- R5: A lock command (op 3) sets the lock bit of the indexed block. Lock bits are cleared only by `rst_n`.
- R6: While `wp_n` is low, protect and unprotect commands to a block whose lock bit is set are ignored. `wp_n` is sampled in the same cycle as the command. Unlocked blocks still accept these commands.
- R7: While `wp_n` is high, lock bits have no effect on protect and unprotect commands.
- R8: A status read (op 5) raises `stat_vld` for one cycle, one clock later. `stat` then holds the protect bit in bit 0, the lock bit in bit 1 and the error flag in bit 2. For an index of 71 or higher, bits 0 and 1 are 0.
- R9: A soft reset command (op 6) clears the error flag and changes no protect or lock bit.
- R10: When `cmd_valid` is low, or when the op is 0 or 7, no state changes and no response is raised.
- R11: Protect, unprotect and lock commands with an index of 71 or higher change no block's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (0 idle, 1 protect, 2 unprotect, 3 lock, 4 modify, 5 status, 6 soft reset, 7 idle) |
| cmd_blk | input | 7 | Block index of the command |
| wp_n | input | 1 | Active-low write-protect input |
| mod_ok | output | 1 | Modify request granted (one-cycle pulse) |
| mod_deny | output | 1 | Modify request refused (one-cycle pulse) |
| stat_vld | output | 1 | Status word valid (one-cycle pulse) |
| stat | output | 3 | Status word: bit 2 error, bit 1 lock, bit 0 protect |

## Verification
The write-protect input and a protect or unprotect command meet in the same cycle. The freeze decision uses `wp_n` as sampled with the command, so it must not lag by a cycle. The bench drives `wp_n` low together with commands aimed at a locked block, and again at an unlocked block. It then drives `wp_n` high together with a command aimed at the locked block. Each outcome is judged by a later modify request or status read on that block. Frozen blocks must keep their protect bit. Unlocked blocks, and locked blocks with `wp_n` high, must follow the command.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_PROT   = 3'd1,
        OP_UNPROT = 3'd2,
        OP_LOCK   = 3'd3,
        OP_MODIFY = 3'd4,
        OP_STATUS = 3'd5,
        OP_SRST   = 3'd6,
        OP_RSVD   = 3'd7
    } bp_op_e;

    typedef struct packed {
        logic err;
        logic lock;
        logic prot;
    } bp_stat_t;

endpackage

// File: rtl/bp_blk_decode.sv
`timescale 1ns/1ps
module bp_blk_decode #(
    parameter int NUM_BLOCKS = 71,
    parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
    input  logic [IDX_W-1:0]      blk,
    output logic [NUM_BLOCKS-1:0] hit,
    output logic                  in_range
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_BLOCKS);

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_hit
        assign hit[i] = (blk == IDX_W'(i));
    end

    assign in_range = ({1'b0, blk} < LIMIT);

    always_comb begin
        assert ($onehot0(hit)) else $error("AST_HIT_ONEHOT"); // R11
    end
endmodule

// File: rtl/bp_state_array.sv
`timescale 1ns/1ps
module bp_state_array #(
    parameter int NUM_BLOCKS = 71
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BLOCKS-1:0] hit,
    input  logic                  do_prot,
    input  logic                  do_unprot,
    input  logic                  do_lock,
    input  logic                  wp_n,
    output logic [NUM_BLOCKS-1:0] prot_vec,
    output logic [NUM_BLOCKS-1:0] lock_vec
);
    typedef struct packed {
        logic [NUM_BLOCKS-1:0] prot;
        logic [NUM_BLOCKS-1:0] lock;
    } arr_t;

    arr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (hit[i] && !(st_q.lock[i] && !wp_n)) begin
                if (do_prot)
                    st_d.prot[i] = 1'b1;
                else if (do_unprot)
                    st_d.prot[i] = 1'b0;
            end
            if (hit[i] && do_lock)
                st_d.lock[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prot <= '1;
            st_q.lock <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_vec = st_q.prot;
    assign lock_vec = st_q.lock;

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_chk
        AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_vec[i] && !wp_n) |=> (prot_vec[i] == $past(prot_vec[i]))); // R6
        AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            lock_vec[i] |=> lock_vec[i]); // R5
    end
endmodule

// File: rtl/bp_status_mux.sv
`timescale 1ns/1ps
module bp_status_mux #(
    parameter int NUM_BLOCKS = 71
) (
    input  logic [NUM_BLOCKS-1:0] hit,
    input  logic [NUM_BLOCKS-1:0] prot_vec,
    input  logic [NUM_BLOCKS-1:0] lock_vec,
    output logic                  sel_prot,
    output logic                  sel_lock
);
    assign sel_prot = |(prot_vec & hit);
    assign sel_lock = |(lock_vec & hit);
endmodule

// File: rtl/blk_protect_unit.sv
`timescale 1ns/1ps
module blk_protect_unit #(
    parameter int NUM_BLOCKS = 71,
    parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_blk,
    input  logic             wp_n,
    output logic             mod_ok,
    output logic             mod_deny,
    output logic             stat_vld,
    output logic [2:0]       stat
);
    import bp_pkg::*;

    typedef struct packed {
        logic     mod_ok;
        logic     mod_deny;
        logic     stat_vld;
        bp_stat_t stat;
        logic     err;
    } resp_t;

    resp_t  r_d, r_q;
    bp_op_e op;
    logic [NUM_BLOCKS-1:0] hit, prot_vec, lock_vec;
    logic in_range, sel_prot, sel_lock;
    logic do_prot, do_unprot, do_lock;

    assign op        = bp_op_e'(cmd_op);
    assign do_prot   = cmd_valid && (op == OP_PROT);
    assign do_unprot = cmd_valid && (op == OP_UNPROT);
    assign do_lock   = cmd_valid && (op == OP_LOCK);

    bp_blk_decode #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_dec (
        .blk      (cmd_blk),
        .hit      (hit),
        .in_range (in_range)
    );

    bp_state_array #(.NUM_BLOCKS(NUM_BLOCKS)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .do_prot   (do_prot),
        .do_unprot (do_unprot),
        .do_lock   (do_lock),
        .wp_n      (wp_n),
        .prot_vec  (prot_vec),
        .lock_vec  (lock_vec)
    );

    bp_status_mux #(.NUM_BLOCKS(NUM_BLOCKS)) u_mux (
        .hit      (hit),
        .prot_vec (prot_vec),
        .lock_vec (lock_vec),
        .sel_prot (sel_prot),
        .sel_lock (sel_lock)
    );

    always_comb begin
        r_d     = '0;
        r_d.err = r_q.err;
        if (cmd_valid) begin
            case (op)
                OP_MODIFY: begin
                    r_d.mod_ok   = in_range && !sel_prot;
                    r_d.mod_deny = !(in_range && !sel_prot);
                    if (r_d.mod_deny)
                        r_d.err = 1'b1;
                end
                OP_STATUS: begin
                    r_d.stat_vld  = 1'b1;
                    r_d.stat.err  = r_q.err;
                    r_d.stat.lock = sel_lock;
                    r_d.stat.prot = sel_prot;
                    r_d.err       = 1'b0;
                end
                OP_SRST: r_d.err = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign mod_ok   = r_q.mod_ok;
    assign mod_deny = r_q.mod_deny;
    assign stat_vld = r_q.stat_vld;
    assign stat     = r_q.stat;

    AST_MOD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mod_ok && mod_deny)); // R3
    AST_MOD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4) |=> (mod_ok || mod_deny)); // R3
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5) |=> (stat_vld && !r_q.err)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !(mod_ok || mod_deny || stat_vld)); // R10
    AST_RESP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mod_ok, mod_deny, stat_vld})); // R8
endmodule

// File: tb/test_blk_protect_unit.sv
`timescale 1ns/1ps
module test_blk_protect_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [6:0] cmd_blk = 7'd0;
    logic       wp_n = 1'b1;
    logic       mod_ok, mod_deny, stat_vld;
    logic [2:0] stat;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    blk_protect_unit i_blk_protect_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .wp_n(wp_n), .mod_ok(mod_ok), .mod_deny(mod_deny),
        .stat_vld(stat_vld), .stat(stat)
    );

    // vector: [21:18] req, [17] valid, [16:14] op, [13:7] blk, [6] wp_n,
    //         [5] ok, [4] deny, [3] stat_vld, [2:0] stat
    localparam int NV = 31;
    localparam logic [21:0] VEC [0:NV-1] = '{
        {4'd3,  1'b1, 3'd4, 7'd0,   1'b1, 1'b0, 1'b1, 1'b0, 3'b000}, // R3 protected block refused
        {4'd4,  1'b1, 3'd5, 7'd0,   1'b1, 1'b0, 1'b0, 1'b1, 3'b101}, // R4 error reported
        {4'd4,  1'b1, 3'd5, 7'd0,   1'b1, 1'b0, 1'b0, 1'b1, 3'b001}, // R4 error cleared by read
        {4'd2,  1'b1, 3'd2, 7'd5,   1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R2 unprotect 5
        {4'd2,  1'b1, 3'd4, 7'd5,   1'b1, 1'b1, 1'b0, 1'b0, 3'b000}, // R2 granted next cycle
        {4'd4,  1'b1, 3'd5, 7'd5,   1'b1, 1'b0, 1'b0, 1'b1, 3'b000}, // R4 grant leaves no error
        {4'd2,  1'b1, 3'd4, 7'd6,   1'b1, 1'b0, 1'b1, 1'b0, 3'b000}, // R2 neighbour untouched
        {4'd9,  1'b1, 3'd6, 7'd0,   1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R9 soft reset
        {4'd9,  1'b1, 3'd5, 7'd5,   1'b1, 1'b0, 1'b0, 1'b1, 3'b000}, // R9 err cleared, block 5 still open
        {4'd5,  1'b1, 3'd3, 7'd5,   1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R5 lock 5
        {4'd5,  1'b1, 3'd5, 7'd5,   1'b1, 1'b0, 1'b0, 1'b1, 3'b010}, // R5 lock visible
        {4'd6,  1'b1, 3'd1, 7'd5,   1'b0, 1'b0, 1'b0, 1'b0, 3'b000}, // R6 protect frozen
        {4'd6,  1'b1, 3'd4, 7'd5,   1'b0, 1'b1, 1'b0, 1'b0, 3'b000}, // R6 still unprotected
        {4'd7,  1'b1, 3'd1, 7'd5,   1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R7 protect applies
        {4'd7,  1'b1, 3'd5, 7'd5,   1'b1, 1'b0, 1'b0, 1'b1, 3'b011}, // R7 now protected
        {4'd6,  1'b1, 3'd2, 7'd5,   1'b0, 1'b0, 1'b0, 1'b0, 3'b000}, // R6 unprotect frozen
        {4'd6,  1'b1, 3'd5, 7'd5,   1'b0, 1'b0, 1'b0, 1'b1, 3'b011}, // R6 still protected
        {4'd6,  1'b1, 3'd2, 7'd70,  1'b0, 1'b0, 1'b0, 1'b0, 3'b000}, // R6 unlocked block accepts
        {4'd3,  1'b1, 3'd4, 7'd70,  1'b1, 1'b1, 1'b0, 1'b0, 3'b000}, // R3 top block granted
        {4'd3,  1'b1, 3'd4, 7'd71,  1'b1, 1'b0, 1'b1, 1'b0, 3'b000}, // R3 out of range refused
        {4'd11, 1'b1, 3'd3, 7'd71,  1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R11 lock out of range
        {4'd11, 1'b1, 3'd1, 7'd127, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R11 protect out of range
        {4'd8,  1'b1, 3'd5, 7'd71,  1'b1, 1'b0, 1'b0, 1'b1, 3'b100}, // R8 out of range status
        {4'd10, 1'b0, 3'd1, 7'd70,  1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R10 valid low
        {4'd10, 1'b1, 3'd7, 7'd70,  1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R10 op 7
        {4'd10, 1'b1, 3'd0, 7'd70,  1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R10 op 0
        {4'd10, 1'b1, 3'd5, 7'd70,  1'b1, 1'b0, 1'b0, 1'b1, 3'b000}, // R10 block 70 unchanged
        {4'd4,  1'b1, 3'd4, 7'd6,   1'b1, 1'b0, 1'b1, 1'b0, 3'b000}, // R4 set error
        {4'd9,  1'b1, 3'd6, 7'd5,   1'b1, 1'b0, 1'b0, 1'b0, 3'b000}, // R9 soft reset
        {4'd9,  1'b1, 3'd5, 7'd5,   1'b1, 1'b0, 1'b0, 1'b1, 3'b011}, // R9 bits kept, err clear
        {4'd7,  1'b1, 3'd2, 7'd5,   1'b1, 1'b0, 1'b0, 1'b0, 3'b000}  // R7 locked but wp high
    };

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic issue(input logic v, input logic [2:0] op, input logic [6:0] b, input logic w);
        cmd_valid = v; cmd_op = op; cmd_blk = b; wp_n = w;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic expect_resp(input string req, input logic ok, input logic dn,
                               input logic sv, input logic [2:0] st);
        checks++;
        if (mod_ok !== ok || mod_deny !== dn || stat_vld !== sv || (sv && stat !== st)) begin
            errors++;
            $display("FAIL %s: ok/deny/vld/stat = %b/%b/%b/%b, expected %b/%b/%b/%b",
                     req, mod_ok, mod_deny, stat_vld, stat, ok, dn, sv, st);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: cycles %0d, expected below 20000", cycles);
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_resp("R1 in reset", 1'b0, 1'b0, 1'b0, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        expect_resp("R1 after release", 1'b0, 1'b0, 1'b0, 3'b000);
        // R1: every block protected, unlocked, no error
        for (int b = 0; b < 71; b++) begin
            issue(1'b1, 3'd5, 7'(b), 1'b1);
            expect_resp("R1 power-up status", 1'b0, 1'b0, 1'b1, 3'b001);
        end
        for (int k = 0; k < NV; k++) begin
            issue(VEC[k][17], VEC[k][16:14], VEC[k][13:7], VEC[k][6]);
            expect_resp($sformatf("R%0d vector %0d", VEC[k][21:18], k),
                        VEC[k][5], VEC[k][4], VEC[k][3], VEC[k][2:0]);
        end
        issue(1'b1, 3'd5, 7'd5, 1'b0);
        expect_resp("R7 unprotect under wp high", 1'b0, 1'b0, 1'b1, 3'b010);
        // R1 / R5: reset mid-run restores protection and clears locks
        rst_n = 1'b0;
        @(negedge clk);
        expect_resp("R1 outputs in reset", 1'b0, 1'b0, 1'b0, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        issue(1'b1, 3'd5, 7'd5, 1'b0);
        expect_resp("R5 lock cleared by reset", 1'b0, 1'b0, 1'b1, 3'b001);
        issue(1'b1, 3'd2, 7'd5, 1'b0);
        issue(1'b1, 3'd4, 7'd5, 1'b0);
        expect_resp("R5 unlocked after reset", 1'b1, 1'b0, 1'b0, 3'b000);
        issue(1'b1, 3'd4, 7'd70, 1'b1);
        expect_resp("R1 block 70 protected again", 1'b0, 1'b1, 1'b0, 3'b000);
        done = 1'b1;
        report();
        $finish;
    end
endmodule